// File: doc/BRIEF.md
# Four-Phase Low-Transition Link Receiver

This block receives a narrow source-clocked link made of five data wires, one flag wire and a pair of staggered strobe wires. The strobe pair walks through a four-step Gray sequence for every data group. The order in which the two strobe wires rise tells the receiver whether the group was sent complemented. A pulse on one strobe wire that falls back without finishing the walk is a clear command.

The data lines carry time-differential bits. A wire toggles for a one and holds its level for a zero, measured against that wire's level at the previous accepted beat. A clear command sets these per-wire reference levels to zero. The receiver rebuilds a 20-bit word from four 5-bit beats, undoes the inversion and presents the word with a one-cycle valid strobe. It also presents the four decoded bits of the flag wire.

All link wires are brought into a faster system clock through a synchronizer chain. Every state change of the synchronized strobe pair is treated as a strobe edge.

Top module: `qpl_link_rx`

## Requirements
- R1: All eight link wires pass through the same SYNC_STAGES-flop synchronizer. Data is sampled in the system cycle where the synchronized strobe pair differs from its previous value.
- R2: A strobe walk 00→01→11→10→00 is an uninverted group. Beats are captured on entry to 01, 11 and 10 and on the return to 00. Beat k (k = 0..3) fills rx_word bits 5k+4 down to 5k.
- R3: A strobe walk 00→10→11→01→00 is an inverted group. All 20 decoded data bits are complemented before they reach rx_word.
- R4: A strobe walk 00→01→00 is a clear command. It sets every wire's reference level to 0 and produces no rx_valid.
- R5: The decoded bit of each wire is its level XOR its level at the last accepted beat. The reference levels are 0 after reset.
- R6: The flag wire is decoded like a data wire. Its decoded bit for beat k appears on rx_aux[k] and is never complemented.
- R7: rx_valid is high for exactly one system cycle. It rises the cycle after the return to 00 that ends a data walk is seen. rx_word and rx_aux hold their values until the next group completes.
- R8: Any other strobe transition sets rx_err, which stays set until reset. Such a transition drops the group in progress and updates no reference level. Further strobe changes are ignored until the pair is back at 00.
- R9: While rst is high, rx_valid, rx_err, rx_word and rx_aux are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System (oversampling) clock |
| rst | input | 1 | Synchronous active-high reset |
| lnk_clk | input | 2 | Staggered strobe pair, bit 0 rises first in an uninverted walk |
| lnk_dat | input | DATA_W (5) | Time-differential data wires |
| lnk_flag | input | 1 | Time-differential flag wire |
| rx_word | output | 20 | Rebuilt data word |
| rx_aux | output | 4 | Decoded flag bits, one per beat |
| rx_valid | output | 1 | One-cycle strobe for a new word |
| rx_err | output | 1 | Sticky illegal-walk flag |

## Verification
Uninverted and inverted groups carry mixed, all-ones and all-zeros words. This separates the strobe-order decode from the complement stage and exposes any swapped beat slot. A clear pulse followed by a group shows whether the reference levels really return to zero, because the line levels no longer match a decode against stale references. A diagonal strobe jump and a mid-walk wrong turn are each followed by a good group. This shows that the error is sticky, that the dropped group yields no word, and that the receiver returns to decoding against the correct references.

// File: rtl/qpl_pkg.sv
package qpl_pkg;

  // Beats per group are fixed by the four-step strobe walk.
  localparam int BEATS = 4;
  localparam int IDX_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UP1,
    ST_UP2,
    ST_UP3,
    ST_DN1,
    ST_DN2,
    ST_DN3,
    ST_HOLD
  } walk_state_t;

  localparam logic [1:0] PAIR_REST = 2'b00;
  localparam logic [1:0] PAIR_LO   = 2'b01;
  localparam logic [1:0] PAIR_HI   = 2'b10;
  localparam logic [1:0] PAIR_BOTH = 2'b11;

endpackage

// File: rtl/qpl_sync.sv
module qpl_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= '0;
          else     chain_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= '0;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/qpl_walk_fsm.sv
module qpl_walk_fsm
  import qpl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       pair_i,
  output logic             beat_en,
  output logic [IDX_W-1:0] beat_idx,
  output logic             group_done,
  output logic             group_inv,
  output logic             clear_cmd,
  output logic             bad_step,
  output logic             err_o
);

  walk_state_t state_q, state_nx;
  logic [1:0]  pair_q;
  logic        changed;

  assign changed = (pair_i != pair_q);

  always_comb begin
    state_nx   = state_q;
    beat_en    = 1'b0;
    beat_idx   = '0;
    group_done = 1'b0;
    group_inv  = 1'b0;
    clear_cmd  = 1'b0;
    bad_step   = 1'b0;
    if (changed) begin
      unique case (state_q)
        ST_IDLE: begin
          if (pair_i == PAIR_LO) begin
            state_nx = ST_UP1; beat_en = 1'b1; beat_idx = 2'd0;
          end else if (pair_i == PAIR_HI) begin
            state_nx = ST_DN1; beat_en = 1'b1; beat_idx = 2'd0;
          end else begin
            bad_step = 1'b1;
          end
        end
        ST_UP1: begin
          if (pair_i == PAIR_REST) begin
            state_nx = ST_IDLE; clear_cmd = 1'b1;
          end else if (pair_i == PAIR_BOTH) begin
            state_nx = ST_UP2; beat_en = 1'b1; beat_idx = 2'd1;
          end else begin
            bad_step = 1'b1;
          end
        end
        ST_UP2: begin
          if (pair_i == PAIR_HI) begin
            state_nx = ST_UP3; beat_en = 1'b1; beat_idx = 2'd2;
          end else begin
            bad_step = 1'b1;
          end
        end
        ST_UP3: begin
          if (pair_i == PAIR_REST) begin
            state_nx = ST_IDLE; beat_en = 1'b1; beat_idx = 2'd3;
            group_done = 1'b1;
          end else begin
            bad_step = 1'b1;
          end
        end
        ST_DN1: begin
          if (pair_i == PAIR_BOTH) begin
            state_nx = ST_DN2; beat_en = 1'b1; beat_idx = 2'd1;
          end else begin
            bad_step = 1'b1;
          end
        end
        ST_DN2: begin
          if (pair_i == PAIR_LO) begin
            state_nx = ST_DN3; beat_en = 1'b1; beat_idx = 2'd2;
          end else begin
            bad_step = 1'b1;
          end
        end
        ST_DN3: begin
          if (pair_i == PAIR_REST) begin
            state_nx = ST_IDLE; beat_en = 1'b1; beat_idx = 2'd3;
            group_done = 1'b1; group_inv = 1'b1;
          end else begin
            bad_step = 1'b1;
          end
        end
        ST_HOLD: begin
          if (pair_i == PAIR_REST) state_nx = ST_IDLE;
        end
        default: state_nx = ST_IDLE;
      endcase
      if (bad_step) state_nx = (pair_i == PAIR_REST) ? ST_IDLE : ST_HOLD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pair_q  <= PAIR_REST;
      err_o   <= 1'b0;
    end else begin
      state_q <= state_nx;
      pair_q  <= pair_i;
      if (bad_step) err_o <= 1'b1;
    end
  end

endmodule

// File: rtl/qpl_beat_decoder.sv
module qpl_beat_decoder
  import qpl_pkg::*;
#(
  parameter int DATA_W = 5,
  localparam int LINE_W = DATA_W + 1,
  localparam int WORD_W = DATA_W * BEATS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] lines_i,
  input  logic              beat_en,
  input  logic [IDX_W-1:0]  beat_idx,
  input  logic              clear_cmd,
  input  logic              group_done,
  input  logic              group_inv,
  output logic [WORD_W-1:0] word_o,
  output logic [BEATS-1:0]  aux_o,
  output logic              valid_o,
  output logic [LINE_W-1:0] ref_o
);

  logic [LINE_W-1:0] ref_q;
  logic [LINE_W-1:0] dec;
  logic [WORD_W-1:0] acc_q, word_nx;
  logic [BEATS-1:0]  aux_q, aux_nx;
  logic [BEATS-1:0]  slot_sel;

  assign dec   = lines_i ^ ref_q;
  assign ref_o = ref_q;

  generate
    for (genvar j = 0; j < BEATS; j++) begin : g_slot
      assign slot_sel[j] = beat_en && (beat_idx == IDX_W'(j));
      assign word_nx[j*DATA_W +: DATA_W] =
        slot_sel[j] ? dec[DATA_W-1:0] : acc_q[j*DATA_W +: DATA_W];
      assign aux_nx[j] = slot_sel[j] ? dec[DATA_W] : aux_q[j];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q   <= '0;
      acc_q   <= '0;
      aux_q   <= '0;
      word_o  <= '0;
      aux_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (clear_cmd)    ref_q <= '0;
      else if (beat_en) ref_q <= lines_i;
      if (beat_en) begin
        acc_q <= word_nx;
        aux_q <= aux_nx;
      end
      if (group_done) begin
        word_o  <= word_nx ^ {WORD_W{group_inv}};
        aux_o   <= aux_nx;
        valid_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/qpl_link_rx.sv
module qpl_link_rx
  import qpl_pkg::*;
#(
  parameter int DATA_W      = 5,
  parameter int SYNC_STAGES = 2,
  localparam int WORD_W     = DATA_W * BEATS,
  localparam int LINE_W     = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        lnk_clk,
  input  logic [DATA_W-1:0] lnk_dat,
  input  logic              lnk_flag,
  output logic [WORD_W-1:0] rx_word,
  output logic [BEATS-1:0]  rx_aux,
  output logic              rx_valid,
  output logic              rx_err
);

  logic [LINE_W+1:0] raw_bus, sync_bus;
  logic [1:0]        pair_s;
  logic [LINE_W-1:0] lines_s;
  logic              beat_en, group_done, group_inv, clear_cmd, bad_step;
  logic [IDX_W-1:0]  beat_idx;
  logic [LINE_W-1:0] ref_lvl;

  assign raw_bus = {lnk_clk, lnk_flag, lnk_dat};
  assign pair_s  = sync_bus[LINE_W+1:LINE_W];
  assign lines_s = sync_bus[LINE_W-1:0];

  qpl_sync #(.WIDTH(LINE_W + 2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(raw_bus), .sync_o(sync_bus)
  );

  qpl_walk_fsm u_walk (
    .clk(clk), .rst(rst), .pair_i(pair_s),
    .beat_en(beat_en), .beat_idx(beat_idx), .group_done(group_done),
    .group_inv(group_inv), .clear_cmd(clear_cmd), .bad_step(bad_step),
    .err_o(rx_err)
  );

  qpl_beat_decoder #(.DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst(rst), .lines_i(lines_s), .beat_en(beat_en),
    .beat_idx(beat_idx), .clear_cmd(clear_cmd), .group_done(group_done),
    .group_inv(group_inv), .word_o(rx_word), .aux_o(rx_aux),
    .valid_o(rx_valid), .ref_o(ref_lvl)
  );

endmodule

// File: rtl/qpl_link_rx_chk.sv
module qpl_link_rx_chk #(
  parameter int REF_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_valid,
  input logic             rx_err,
  input logic [1:0]       pair_s,
  input logic             bad_step,
  input logic             clear_cmd,
  input logic [REF_W-1:0] ref_lvl
);

  // R7
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R7
  valid_at_rest_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(pair_s) == 2'b00);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    rx_err |=> rx_err);

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_err) |-> $past(bad_step));

  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clear_cmd |=> ref_lvl == '0);

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!rx_valid && !rx_err));

endmodule

bind qpl_link_rx qpl_link_rx_chk #(.REF_W(DATA_W + 1)) u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_err(rx_err),
  .pair_s(pair_s), .bad_step(bad_step), .clear_cmd(clear_cmd),
  .ref_lvl(ref_lvl)
);

// File: tb/qpl_link_rx_test.sv
module qpl_link_rx_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  lnk_clk = 2'b00;
  logic [4:0]  lnk_dat = '0;
  logic        lnk_flag = 1'b0;
  logic [19:0] rx_word;
  logic [3:0]  rx_aux;
  logic        rx_valid, rx_err;

  int tests = 0;
  int fails = 0;
  logic [5:0]  ref_m = '0;
  logic [23:0] exp_q [$];
  logic [19:0] last_word = '0;
  logic [3:0]  last_aux = '0;
  logic        prev_valid = 1'b0;

  always #5 clk = ~clk;

  qpl_link_rx uut (
    .clk(clk), .rst(rst), .lnk_clk(lnk_clk), .lnk_dat(lnk_dat),
    .lnk_flag(lnk_flag), .rx_word(rx_word), .rx_aux(rx_aux),
    .rx_valid(rx_valid), .rx_err(rx_err)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pair(input logic [1:0] p);
    lnk_clk = p;
    wait_cyc(5);
  endtask

  // Driver: encodes word/aux into line levels and pushes the expectation (R2, R3, R5, R6).
  task automatic send_group(input logic [19:0] word, input logic [3:0] aux,
                            input bit inv);
    logic [1:0] seq [4];
    if (inv) begin seq[0]=2'b10; seq[1]=2'b11; seq[2]=2'b01; seq[3]=2'b00; end
    else     begin seq[0]=2'b01; seq[1]=2'b11; seq[2]=2'b10; seq[3]=2'b00; end
    exp_q.push_back({aux, word});
    for (int k = 0; k < 4; k++) begin
      logic [4:0] d;
      logic [5:0] lv;
      d  = inv ? ~word[5*k +: 5] : word[5*k +: 5];
      lv = ref_m ^ {aux[k], d};
      lnk_dat  = lv[4:0];
      lnk_flag = lv[5];
      wait_cyc(2);
      set_pair(seq[k]);
      ref_m = lv;
    end
    wait_cyc(3);
  endtask

  // Monitor: pops expectations on each valid strobe (R7 single cycle).
  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        if (prev_valid) check("R7 single-cycle valid", 32'd1, 32'd0);
        if (exp_q.size() == 0) begin
          check("R4/R8 unexpected valid", {8'd0, rx_aux, rx_word}, 32'd0);
        end else begin
          logic [23:0] e;
          e = exp_q.pop_front();
          check("R2/R3 word", {12'd0, rx_word}, {12'd0, e[19:0]});
          check("R6 aux", {28'd0, rx_aux}, {28'd0, e[23:20]});
          last_word = e[19:0];
          last_aux  = e[23:20];
        end
      end
      prev_valid <= rx_valid;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait_cyc(4);
    // R9: outputs quiet during reset
    check("R9 valid in reset", {31'd0, rx_valid}, 32'd0);
    check("R9 err in reset", {31'd0, rx_err}, 32'd0);
    check("R9 word in reset", {12'd0, rx_word}, 32'd0);
    check("R9 aux in reset", {28'd0, rx_aux}, 32'd0);
    rst = 1'b0;
    wait_cyc(4);

    // R1, R2, R5: uninverted group with mixed data
    send_group(20'hABCDE, 4'h5, 1'b0);
    // R3: inverted group
    send_group(20'h12345, 4'hA, 1'b1);
    // R2 all ones, R3 all zeros inverted
    send_group(20'hFFFFF, 4'hF, 1'b0);
    send_group(20'h00000, 4'h0, 1'b1);
    // R7: word held after strobe
    wait_cyc(10);
    check("R7 word held", {12'd0, rx_word}, {12'd0, last_word});
    check("R7 aux held", {28'd0, rx_aux}, {28'd0, last_aux});

    // R4: clear pulse resets references, no valid
    lnk_dat = 5'h1B; lnk_flag = 1'b1;
    wait_cyc(2);
    set_pair(2'b01);
    set_pair(2'b00);
    ref_m = '0;
    check("R4 no valid on clear", exp_q.size(), 32'd0);
    send_group(20'h5A5A5, 4'h9, 1'b0);
    check("R8 no error yet", {31'd0, rx_err}, 32'd0);

    // R8: diagonal jump is illegal
    set_pair(2'b11);
    check("R8 err after 00->11", {31'd0, rx_err}, 32'd1);
    set_pair(2'b00);
    send_group(20'hC3C3C, 4'h6, 1'b1);

    // R8: wrong turn mid-walk drops the group
    lnk_dat = ref_m[4:0] ^ 5'h07; lnk_flag = ref_m[5];
    wait_cyc(2);
    set_pair(2'b01);
    ref_m = {lnk_flag, lnk_dat};
    set_pair(2'b10);
    set_pair(2'b00);
    check("R8 dropped group", exp_q.size(), 32'd0);
    send_group(20'h0F0F1, 4'h3, 1'b0);
    check("R8 err sticky", {31'd0, rx_err}, 32'd1);

    wait_cyc(10);
    check("R2 all groups seen", exp_q.size(), 32'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule